// File: doc/BRIEF.md
# Dual Match-Compare Timer

The block holds two independent 32-bit up-counters. Each counter has its own prescaler and its own match register. While a channel runs, its prescaler divides the input clock by D+1, and each prescaler tick advances the counter by one. When compare is enabled and the count equals the match value, the channel's bit in a shared status register is set. Each channel drives one interrupt line, which is that status bit gated by the channel's interrupt enable.

Software reaches the block over a simple word-addressed register bus. A write takes effect on the clock edge on which `we_i` is sampled high. A read is combinational from `addr_i`. To arm a one-shot event, software clears the counter, loads a match value and sets the three enable bits. To retire the event, it clears those bits and writes a one to the status bit.

Top module: `match_timer`

## Requirements
- R1: After reset every control, match, counter and status register reads zero and both interrupt lines are low.
- R2: Control registers for channels 0 and 1 sit at 0x00 and 0x04, match registers at 0x18 and 0x1C, and counter registers at 0x48 and 0x4C. Each register reads back what was last written, except that control bits [15:3] always read zero.
- R3: Control bit 0 enables counting, bit 1 enables compare and bit 2 enables the interrupt. Writing 0x7 with a zero divider fully starts a channel.
- R4: Control bits [31:16] hold a divider D. A running counter advances once every D+1 clock cycles, and the first advance lands D+1 cycles after the enabling write.
- R5: A write to a counter register loads the written value on that edge and takes priority over the increment, so the counter also accepts writes while it runs.
- R6: The status bit of channel n is set on the clock after a cycle in which bits 0 and 1 of that channel are set and count equals match.
- R7: Interrupt output n is high exactly when status bit n is set and control bit 2 of channel n is set.
- R8: Status sits at 0x60, with bit n belonging to channel n and all other bits reading zero. Writing a 1 to a bit clears it, writing 0 leaves it, and writing 0xFFFF clears all bits.
- R9: When a match and a clear of the same status bit fall in the same cycle, the bit stays set.
- R10: After a match the counter keeps incrementing, and it wraps from 0xFFFFFFFF to 0.
- R11: A read from any other offset returns zero, and a write to any other offset changes no register.
- R12: Clearing bit 0 freezes the counter and resets the prescaler, so re-enabling waits a full D+1 cycles for the next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 2 | Per-channel interrupt lines |

## Verification
A table of write/read-back vectors covers every mapped register, the reserved control bits, unmapped offsets and the status register. It separates address decode errors from storage and masking errors. The counting path is run in several ways:
- with a divider of 3, with a pause and a restart, which separates the prescaler period from the restart behaviour;
- with a divider of 0 starting just below wrap, which exercises the wrap;
- with a counter written while the channel runs, which checks write priority.

Match events are raised with and without the interrupt enable, which separates status from the interrupt gate. One match is held steady with a large divider and cleared at the same time, which shows whether set beats clear.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned CTRL_OFS  = 'h00;
  localparam int unsigned MATCH_OFS = 'h18;
  localparam int unsigned CNT_OFS   = 'h48;
  localparam int unsigned STAT_OFS  = 'h60;
  localparam int unsigned STRIDE    = 4;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned CMP_BIT   = 1;
  localparam int unsigned IEN_BIT   = 2;
  localparam int unsigned DIV_LSB   = 16;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned DIVW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o
);
  logic [DIVW-1:0] pcnt_q;

  // >= so a divider lowered mid-period still ticks promptly
  assign tick_o = run_i && (pcnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!run_i || tick_o)  pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end

  assert_idle_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pcnt_q == '0));
  assert_tick_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pcnt_q == '0));
endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned DIVW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          match_we_i,
  input  logic          cnt_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] count_o,
  output logic          hit_o,
  output logic          ien_o
);
  logic            run_q, cmp_q, ien_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   match_q, count_q;
  logic            tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cmp_q <= 1'b0;
      ien_q <= 1'b0;
      div_q <= '0;
    end else if (ctrl_we_i) begin
      run_q <= wdata_i[RUN_BIT];
      cmp_q <= wdata_i[CMP_BIT];
      ien_q <= wdata_i[IEN_BIT];
      div_q <= wdata_i[DIV_LSB +: DIVW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_q <= '0;
    else if (match_we_i) match_q <= wdata_i;
  end

  mt_prescaler #(.DIVW(DIVW)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .div_i  (div_q),
    .tick_o (tick)
  );

  // software load beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_we_i) count_q <= wdata_i;
    else if (tick)     count_q <= count_q + 1'b1;
  end

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[RUN_BIT]          = run_q;
    ctrl_o[CMP_BIT]          = cmp_q;
    ctrl_o[IEN_BIT]          = ien_q;
    ctrl_o[DIV_LSB +: DIVW]  = div_q;
  end

  assign match_o = match_q;
  assign count_o = count_q;
  assign hit_o   = run_q && cmp_q && (count_q == match_q);
  assign ien_o   = ien_q;

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_we_i) |=> (count_q == $past(count_q) + 1'b1));
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (count_q == $past(wdata_i)));
  assert_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_we_i) |=> $stable(count_q));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  localparam int unsigned DIVW = DW - DIV_LSB;
  localparam logic [AW-1:0] A_STAT = AW'(STAT_OFS);

  logic [DW-1:0]  ctrl_v  [NCH];
  logic [DW-1:0]  match_v [NCH];
  logic [DW-1:0]  cnt_v   [NCH];
  logic [NCH-1:0] hit, ien, stat_q, stat_clr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CTRL  = AW'(CTRL_OFS  + STRIDE * i);
    localparam logic [AW-1:0] A_MATCH = AW'(MATCH_OFS + STRIDE * i);
    localparam logic [AW-1:0] A_CNT   = AW'(CNT_OFS   + STRIDE * i);

    mt_channel #(.DW(DW), .DIVW(DIVW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (we_i && addr_i == A_CTRL),
      .match_we_i (we_i && addr_i == A_MATCH),
      .cnt_we_i   (we_i && addr_i == A_CNT),
      .wdata_i    (wdata_i),
      .ctrl_o     (ctrl_v[i]),
      .match_o    (match_v[i]),
      .count_o    (cnt_v[i]),
      .hit_o      (hit[i]),
      .ien_o      (ien[i])
    );

    assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> stat_q[i]);
    assert_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[i]) |-> $past(hit[i]));
    assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_clr[i] && !hit[i]) |=> !stat_q[i]);
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_clr[i] && hit[i]) |=> stat_q[i]);
  end

  assign stat_clr = (we_i && addr_i == A_STAT) ? wdata_i[NCH-1:0] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | hit;
  end

  assign irq_o = stat_q & ien;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_STAT) rdata_o[NCH-1:0] = stat_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(CTRL_OFS  + STRIDE * i)) rdata_o = ctrl_v[i];
      if (addr_i == AW'(MATCH_OFS + STRIDE * i)) rdata_o = match_v[i];
      if (addr_i == AW'(CNT_OFS   + STRIDE * i)) rdata_o = cnt_v[i];
    end
  end
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  match_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam int NV = 9;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h04, 8'h18, 8'h1C, 8'h48,
                                          8'h4C, 8'h30, 8'h64, 8'h60};
  localparam logic [31:0] V_WR   [NV] = '{32'h0005_FFFE, 32'h1234_ABCC, 32'hCAFE_F00D,
                                          32'h0000_0007, 32'h89AB_CDEF, 32'h0000_0042,
                                          32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_FFFF};
  localparam logic [31:0] V_EXP  [NV] = '{32'h0005_0006, 32'h1234_0004, 32'hCAFE_F00D,
                                          32'h0000_0007, 32'h89AB_CDEF, 32'h0000_0042,
                                          32'h0, 32'h0, 32'h0};

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(rdata_o, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    rd(8'h00, 0, "R1 ctrl0"); rd(8'h04, 0, "R1 ctrl1");
    rd(8'h18, 0, "R1 match0"); rd(8'h1C, 0, "R1 match1");
    rd(8'h48, 0, "R1 cnt0"); rd(8'h4C, 0, "R1 cnt1");
    rd(8'h60, 0, "R1 status");
    chk({30'd0, irq_o}, 0, "R1 irq");

    // R2 R3 R11 R8 register table
    for (int k = 0; k < NV; k++) begin
      wr(V_ADDR[k], V_WR[k]);
      rd(V_ADDR[k], V_EXP[k], "R2 R11 table readback");
    end
    rd(8'h18, 32'hCAFE_F00D, "R11 unmapped write left match0");
    rd(8'h00, 32'h0005_0006, "R11 unmapped write left ctrl0");
    wr(8'h00, 0); wr(8'h04, 0);

    // R4 prescaler D=3
    wr(8'h48, 0);
    wr(8'h00, (32'd3 << 16) | 32'h1);
    idle(3); rd(8'h48, 0, "R4 before first tick");
    idle(1); rd(8'h48, 1, "R4 first tick");
    idle(4); rd(8'h48, 2, "R4 second tick");
    // R12 stop and restart
    wr(8'h00, 0);
    idle(10); rd(8'h48, 2, "R12 frozen");
    wr(8'h00, (32'd3 << 16) | 32'h1);
    idle(3); rd(8'h48, 2, "R12 prescaler restarted");
    idle(1); rd(8'h48, 3, "R12 first tick after restart");
    wr(8'h00, 0);

    // R5 write while running
    wr(8'h00, 1);
    idle(3);
    wr(8'h48, 100);
    rd(8'h48, 100, "R5 load while running");
    idle(1); rd(8'h48, 101, "R5 counts on from load");
    wr(8'h00, 0);

    // R10 wrap
    wr(8'h48, 32'hFFFF_FFFE);
    wr(8'h00, 1);
    idle(1); rd(8'h48, 32'hFFFF_FFFF, "R10 top");
    idle(1); rd(8'h48, 0, "R10 wrap");
    idle(1); rd(8'h48, 1, "R10 after wrap");
    wr(8'h00, 0);

    // R6 R7 R8 match on channel 0
    wr(8'h48, 0); wr(8'h18, 5);
    wr(8'h00, 7);
    idle(5);
    rd(8'h60, 0, "R6 no status before match");
    chk({30'd0, irq_o}, 0, "R7 no irq before match");
    idle(1);
    rd(8'h60, 1, "R6 status after match");
    chk({30'd0, irq_o}, 1, "R7 irq0 raised");
    idle(4); rd(8'h48, 10, "R10 counts past match");
    wr(8'h60, 0); rd(8'h60, 1, "R8 writing zero keeps bit");
    wr(8'h60, 1); rd(8'h60, 0, "R8 w1c clears");
    chk({30'd0, irq_o}, 0, "R7 irq0 dropped");
    wr(8'h00, 0);

    // R7 masked interrupt on channel 1
    wr(8'h4C, 0); wr(8'h1C, 2);
    wr(8'h04, 3);
    idle(3);
    rd(8'h60, 2, "R6 channel1 status");
    chk({30'd0, irq_o}, 0, "R7 masked irq1");
    wr(8'h04, 7);
    chk({30'd0, irq_o}, 2, "R7 irq1 after enable");
    wr(8'h60, 32'hFFFF);
    rd(8'h60, 0, "R8 clear all");
    chk({30'd0, irq_o}, 0, "R7 irq1 cleared");
    wr(8'h04, 0);

    // R9 set wins over clear
    wr(8'h1C, 9); wr(8'h4C, 9);
    wr(8'h04, (32'd100 << 16) | 32'h3);
    wr(8'h60, 2);
    rd(8'h60, 2, "R9 set beats clear");
    wr(8'h04, 0);
    rd(8'h60, 2, "R9 status held after stop");
    wr(8'h60, 2);
    rd(8'h60, 0, "R8 clear after stop");

    summary();
  end
endmodule